// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits next to a small 8-bit controller core and decides which of eleven peripheral request lines the core should service next. Software configures it through four byte-wide registers on a simple address/data port. Two registers enable sources. Two registers assign each source to a high or a low level. One bit acts as a master switch for every source.

Each cycle the block looks at the pending, enabled requests. A high-level request beats any low-level one. Among requests at the same level, a fixed polling order decides. The winner's 16-bit entry address is registered and offered to the core together with a request flag. The block keeps re-deciding until the core acknowledges. On acknowledge, it marks the winning level as in service. A return strobe from the core releases the most urgent level still marked.

Top module: `dual_level_intc`

## Requirements
- R1: The registers live at addresses A8h (enable group A: bit 7 master enable, bits 4..0 = UART, timer 1, external 1, timer 0, external 0), C8h (enable group B: bits 5..0 = transmit error, DMA 1, transmit valid, DMA 0, receive error, receive valid), B8h (level group A, same bits as A8h without bit 7) and F8h (level group B, same bits as C8h). A level bit of 1 means high. Unimplemented bits ignore writes and read 0. Any other address reads 0.
- R2: After reset every register bit is 0, no request is offered and no level is in service.
- R3: A source is serviced only when the master enable bit is 1 and its own enable bit is 1.
- R4: Among requests at the same level, the winner follows this order, first wins: external 0 (source index 0), receive valid (1), timer 0 (2), receive error (3), DMA 0 (4), external 1 (5), transmit valid (6), DMA 1 (7), timer 1 (8), transmit error (9), UART (10). Source index i is bit i of `irq_src`.
- R5: Any eligible high-level request wins over every low-level request, whatever their polling positions.
- R6: The entry addresses by source index 0..10 are 0003h, 002Bh, 000Bh, 0033h, 003Bh, 0013h, 0043h, 0053h, 001Bh, 004Bh and 0023h.
- R7: `irq_req`, `irq_vec` and `irq_lvl` are registered from the state of the previous cycle. They are recomputed every cycle until acknowledge, so a newly winning source replaces the offered address.
- R8: An acknowledge while `irq_req` is 1 sets `in_service[irq_lvl]`. In the next cycle `irq_req` is 0.
- R9: While the low level is in service, only high-level requests are offered. While the high level is in service, nothing is offered.
- R10: `reti` clears the high in-service bit if it is set, otherwise the low one. When `reti` and an acknowledge fall in the same cycle, the clear is applied first and then the acknowledge sets its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_src | input | 11 | Request lines, bit i = source index i |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Entry address of the offered source |
| irq_lvl | output | 1 | Level of the offered source (1 = high) |
| irq_ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Return-from-handler strobe |
| in_service | output | 2 | Bit 1 = high level active, bit 0 = low level active |

## Verification
The acknowledge of a preempting high-level request and the return strobe of the interrupted low-level handler can arrive in the same cycle. Both update the in-service state, so their order matters. The bench creates this case by first putting a low-level handler in service and raising a high-level UART request. It then pulses `irq_ack` and `reti` together. The result must be in-service state 10b with the request withdrawn, which shows the clear happened before the set.

// File: rtl/dlic_pkg.sv
package dlic_pkg;

    localparam int NSRC  = 11;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 16;
    localparam int DW    = 8;

    // Sources whose enable/level bits live in register group A (by polling index)
    localparam logic [NSRC-1:0] IN_GRP_A = 11'b101_0010_0101;

    // Writable bits per register
    localparam logic [DW-1:0] ENA_MASK = 8'h9F;
    localparam logic [DW-1:0] ENB_MASK = 8'h3F;
    localparam logic [DW-1:0] LVA_MASK = 8'h1F;
    localparam logic [DW-1:0] LVB_MASK = 8'h3F;

    typedef struct packed {
        logic [DW-1:0] en_a;
        logic [DW-1:0] en_b;
        logic [DW-1:0] lv_a;
        logic [DW-1:0] lv_b;
    } cfg_t;

    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
        logic             lvl;
        logic [1:0]       isv;
    } ctl_t;

    // Bit position of a source inside its register group
    function automatic int grp_pos(input int i);
        int c;
        c = 0;
        for (int k = 0; k < i; k++)
            if (IN_GRP_A[k] == IN_GRP_A[i]) c++;
        return c;
    endfunction

    // Entry address: 8-byte slots starting at 3, slot chosen per source
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] p);
        int slot;
        case (p)
            4'd0:    slot = 0;
            4'd1:    slot = 5;
            4'd2:    slot = 1;
            4'd3:    slot = 6;
            4'd4:    slot = 7;
            4'd5:    slot = 2;
            4'd6:    slot = 8;
            4'd7:    slot = 10;
            4'd8:    slot = 3;
            4'd9:    slot = 9;
            default: slot = 4;
        endcase
        return VEC_W'(slot * 8 + 3);
    endfunction

endpackage

// File: rtl/dlic_regs.sv
module dlic_regs
    import dlic_pkg::*;
#(
    parameter logic [7:0] ADDR_ENA = 8'hA8,
    parameter logic [7:0] ADDR_ENB = 8'hC8,
    parameter logic [7:0] ADDR_LVA = 8'hB8,
    parameter logic [7:0] ADDR_LVB = 8'hF8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      addr,
    input  logic [DW-1:0]   wdata,
    input  logic            we,
    output logic [DW-1:0]   rdata,
    output logic            gen_o,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] hi_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                ADDR_ENA: cfg_d.en_a = wdata & ENA_MASK;
                ADDR_ENB: cfg_d.en_b = wdata & ENB_MASK;
                ADDR_LVA: cfg_d.lv_a = wdata & LVA_MASK;
                ADDR_LVB: cfg_d.lv_b = wdata & LVB_MASK;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (addr)
            ADDR_ENA: rdata = cfg_q.en_a;
            ADDR_ENB: rdata = cfg_q.en_b;
            ADDR_LVA: rdata = cfg_q.lv_a;
            ADDR_LVB: rdata = cfg_q.lv_b;
            default:  rdata = '0;
        endcase
    end

    assign gen_o = cfg_q.en_a[7];

    for (genvar i = 0; i < NSRC; i++) begin : g_map
        localparam int P = grp_pos(i);
        if (IN_GRP_A[i]) begin : g_a
            assign en_o[i] = cfg_q.en_a[P];
            assign hi_o[i] = cfg_q.lv_a[P];
        end else begin : g_b
            assign en_o[i] = cfg_q.en_b[P];
            assign hi_o[i] = cfg_q.lv_b[P];
        end
    end

    // R1: a write to group A never leaves its unimplemented bits set
    assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_ENA) |=> (addr != ADDR_ENA || rdata[6:5] == 2'b00));

endmodule

// File: rtl/dlic_arb.sv
module dlic_arb
    import dlic_pkg::*;
(
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  en,
    input  logic [NSRC-1:0]  hi,
    input  logic             gen,
    input  logic [1:0]       isv,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic             lvl
);

    logic [NSRC-1:0] live, hi_c, lo_c;

    assign live = pend & en & {NSRC{gen}};
    assign hi_c = live & hi  & {NSRC{!isv[1]}};
    assign lo_c = live & ~hi & {NSRC{isv == 2'b00}};

    always_comb begin
        found = 1'b0;
        idx   = '0;
        lvl   = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (lo_c[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                lvl   = 1'b0;
            end
        end
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_c[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                lvl   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_level_intc.sv
module dual_level_intc
    import dlic_pkg::*;
#(
    parameter logic [7:0] ADDR_ENA = 8'hA8,
    parameter logic [7:0] ADDR_ENB = 8'hC8,
    parameter logic [7:0] ADDR_LVA = 8'hB8,
    parameter logic [7:0] ADDR_LVB = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             reg_we,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NSRC-1:0]  irq_src,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_lvl,
    input  logic             irq_ack,
    input  logic             reti,
    output logic [1:0]       in_service
);

    logic             gen_w;
    logic [NSRC-1:0]  en_w, hi_w;
    logic             found_w, lvl_w;
    logic [IDX_W-1:0] idx_w;
    ctl_t             ctl_d, ctl_q;
    logic             take;

    dlic_regs #(
        .ADDR_ENA(ADDR_ENA), .ADDR_ENB(ADDR_ENB),
        .ADDR_LVA(ADDR_LVA), .ADDR_LVB(ADDR_LVB)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .rdata (reg_rdata),
        .gen_o (gen_w),
        .en_o  (en_w),
        .hi_o  (hi_w)
    );

    dlic_arb u_arb (
        .pend  (irq_src),
        .en    (en_w),
        .hi    (hi_w),
        .gen   (gen_w),
        .isv   (ctl_q.isv),
        .found (found_w),
        .idx   (idx_w),
        .lvl   (lvl_w)
    );

    always_comb begin
        ctl_d = ctl_q;
        take  = irq_ack && ctl_q.req;
        // release first, then capture
        if (reti) begin
            if (ctl_q.isv[1]) ctl_d.isv[1] = 1'b0;
            else              ctl_d.isv[0] = 1'b0;
        end
        if (take) ctl_d.isv[ctl_q.lvl] = 1'b1;
        ctl_d.req = found_w && !take;
        ctl_d.vec = found_w ? vec_of(idx_w) : '0;
        ctl_d.lvl = found_w && lvl_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_req    = ctl_q.req;
    assign irq_vec    = ctl_q.vec;
    assign irq_lvl    = ctl_q.lvl;
    assign in_service = ctl_q.isv;

    assert_gen_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(gen_w));

    assert_ack_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    assert_ack_marks_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && irq_lvl) |=> in_service[1]);

    assert_hi_blocks_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_service[1] |-> !irq_req);

    assert_lo_only_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service[0] && irq_req) |-> irq_lvl);

    assert_reti_clears_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_service[1] && !(irq_ack && irq_req)) |=> !in_service[1]);

endmodule

// File: tb/dual_level_intc_tb.sv
module dual_level_intc_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_rdata;
    logic [10:0] irq_src = '0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_lvl;
    logic        irq_ack = 1'b0;
    logic        reti = 1'b0;
    logic [1:0]  in_service;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] exp_vec [11] = '{16'h0003, 16'h002B, 16'h000B, 16'h0033, 16'h003B,
                                  16'h0013, 16'h0043, 16'h0053, 16'h001B, 16'h004B,
                                  16'h0023};

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_level_intc u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_src(irq_src),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .irq_ack(irq_ack), .reti(reti), .in_service(in_service)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_src = '0; irq_ack = 1'b0; reti = 1'b0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, tag, reg_rdata, e);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic enable_all_low();
        wr(8'hA8, 8'h9F);
        wr(8'hC8, 8'h3F);
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk(8'hA8, 8'h00, "R2 enA reset");
        rd_chk(8'hC8, 8'h00, "R2 enB reset");
        rd_chk(8'hB8, 8'h00, "R2 lvA reset");
        rd_chk(8'hF8, 8'h00, "R2 lvB reset");
        chk(irq_req == 1'b0, "R2 no request", irq_req, 0);
        chk(in_service == 2'b00, "R2 nothing in service", in_service, 0);
    endtask

    task automatic t_regs();
        do_reset();
        wr(8'hA8, 8'hFF); wr(8'hC8, 8'hFF); wr(8'hB8, 8'hFF); wr(8'hF8, 8'hFF);
        wr(8'h10, 8'hFF);
        rd_chk(8'hA8, 8'h9F, "R1 enA unimplemented bits");
        rd_chk(8'hC8, 8'h3F, "R1 enB unimplemented bits");
        rd_chk(8'hB8, 8'h1F, "R1 lvA unimplemented bits");
        rd_chk(8'hF8, 8'h3F, "R1 lvB unimplemented bits");
        rd_chk(8'h10, 8'h00, "R1 unmapped address");
    endtask

    task automatic t_gate();
        do_reset();
        wr(8'hA8, 8'h1F); wr(8'hC8, 8'h3F);
        irq_src = 11'h7FF;
        settle();
        chk(irq_req == 1'b0, "R3 master off blocks", irq_req, 0);
        wr(8'hA8, 8'h9E);
        irq_src = 11'h001;
        settle();
        chk(irq_req == 1'b0, "R3 own enable off blocks", irq_req, 0);
        wr(8'hA8, 8'h9F);
        settle();
        chk(irq_req == 1'b1, "R3 both enables pass", irq_req, 1);
        chk(irq_vec == 16'h0003, "R6 external 0 entry", irq_vec, 16'h0003);
    endtask

    task automatic t_vectors();
        do_reset();
        enable_all_low();
        for (int i = 0; i < 11; i++) begin
            irq_src = 11'(1 << i);
            settle();
            chk(irq_req && irq_vec == exp_vec[i], $sformatf("R6 entry of source %0d", i), irq_vec, exp_vec[i]);
        end
    endtask

    task automatic t_order();
        do_reset();
        enable_all_low();
        for (int i = 0; i < 11; i++) begin
            irq_src = 11'h7FF << i;
            settle();
            chk(irq_vec == exp_vec[i], $sformatf("R4 polling winner from %0d", i), irq_vec, exp_vec[i]);
        end
    endtask

    task automatic t_prio();
        do_reset();
        enable_all_low();
        wr(8'hB8, 8'h10);
        irq_src = 11'h7FF;
        settle();
        chk(irq_vec == 16'h0023 && irq_lvl, "R5 high UART beats all low", irq_vec, 16'h0023);
        wr(8'hF8, 8'h20);
        settle();
        chk(irq_vec == 16'h004B && irq_lvl, "R5 high order transmit error before UART", irq_vec, 16'h004B);
    endtask

    task automatic t_hold();
        do_reset();
        enable_all_low();
        irq_src = 11'h020;
        settle();
        chk(irq_vec == 16'h0013, "R7 external 1 offered", irq_vec, 16'h0013);
        repeat (3) @(negedge clk);
        chk(irq_req == 1'b1, "R7 held until acknowledge", irq_req, 1);
        irq_src = 11'h021;
        @(posedge clk); @(negedge clk);
        chk(irq_vec == 16'h0003, "R7 re-evaluated one cycle later", irq_vec, 16'h0003);
    endtask

    task automatic t_nest();
        do_reset();
        enable_all_low();
        irq_src = 11'h001;
        settle();
        pulse_ack();
        chk(in_service == 2'b01, "R8 low marked in service", in_service, 2'b01);
        chk(irq_req == 1'b0, "R8 request withdrawn", irq_req, 0);
        irq_src = 11'h021;
        settle();
        chk(irq_req == 1'b0, "R9 equal level blocked", irq_req, 0);
        wr(8'hB8, 8'h10);
        irq_src = 11'h421;
        settle();
        chk(irq_req && irq_lvl && irq_vec == 16'h0023, "R9 high preempts low", irq_vec, 16'h0023);
        pulse_ack();
        chk(in_service == 2'b11, "R8 high marked in service", in_service, 2'b11);
        irq_src = 11'h000;
        settle();
        chk(irq_req == 1'b0, "R9 nothing during high", irq_req, 0);
        pulse_reti();
        chk(in_service == 2'b01, "R10 reti clears high first", in_service, 2'b01);
        pulse_reti();
        chk(in_service == 2'b00, "R10 reti clears low", in_service, 2'b00);
    endtask

    task automatic t_coincide();
        do_reset();
        enable_all_low();
        wr(8'hB8, 8'h10);
        irq_src = 11'h001;
        settle();
        pulse_ack();
        chk(in_service == 2'b01, "R10 setup low in service", in_service, 2'b01);
        irq_src = 11'h400;
        settle();
        chk(irq_req && irq_lvl, "R10 setup high offered", irq_lvl, 1);
        irq_ack = 1'b1; reti = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; reti = 1'b0;
        chk(in_service == 2'b10, "R10 clear then set in one cycle", in_service, 2'b10);
        chk(irq_req == 1'b0, "R8 request withdrawn on coincidence", irq_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_gate();
        t_vectors();
        t_order();
        t_prio();
        t_hold();
        t_nest();
        t_coincide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule